// File: doc/BRIEF.md
# Stack Push Width and Data Formatter

This block prepares a single stack push for a processor core that can run code in 16-bit, 32-bit or 64-bit mode. It is given the mode of the current code, a flag saying whether an operand-size override prefix is present, whether the value comes from a register or an immediate, how many bytes the immediate was encoded in, the raw value and the current stack pointer. From these it works out how many bytes go onto the stack and what they are. It also produces the decremented stack pointer and a per-byte write mask for a 64-bit store lane.

The push width comes only from the mode and the prefix. The encoded size of an immediate never changes it, so a push and a later pop of the same kind always move the stack pointer by the same amount. An immediate that is narrower than the push width has its top bit copied into the missing upper bytes. A register value that is wider than the push width is cut down to the push width. All results are registered and show up one clock after an input strobe, together with an output valid pulse.

Top module: `push_fmt`

## Requirements
- R1: With mode code 2'b10 (64-bit; code 2'b11 is handled the same way) the push width is 8 bytes. With the override flag set it is 2 bytes.
- R2: With mode code 2'b01 (32-bit) the push width is 4 bytes. With the override flag set it is 2 bytes.
- R3: With mode code 2'b00 (16-bit) the push width is 2 bytes. With the override flag set it is 4 bytes.
- R4: The new stack pointer is the old one minus the push width, wrapping modulo 2^16 in 16-bit mode, modulo 2^32 in 32-bit mode and modulo 2^64 in 64-bit mode. In 16-bit mode bits 63:16 are copied unchanged from the old pointer, and in 32-bit mode bits 63:32 are.
- R5: For an immediate source (srcIsImm=1), the low immBytes bytes of srcValue (immBytes 1 or 2; any other value means 4) are sign-extended from their top bit. The result is then cut to the push width, and every byte above the push width is zero.
- R6: For a register source (srcIsImm=0), storeData holds the low push-width bytes of srcValue, and every byte above them is zero.
- R7: byteEnable bit i is set exactly when i is less than the push width, so the low 2, 4 or 8 bits are set.
- R8: pushBytes equals the push width (2, 4 or 8). It does not depend on srcIsImm or immBytes.
- R9: A high inValid at a clock edge makes outValid high after that edge, with results for the inputs sampled at that edge. A low inValid makes outValid low after the edge, and the data outputs keep their previous values.
- R10: While rstN is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input strobe |
| cpuMode | input | 2 | Code mode: 00 16-bit, 01 32-bit, 10/11 64-bit |
| sizeOverride | input | 1 | Operand-size override prefix present |
| srcIsImm | input | 1 | 1 = immediate source, 0 = register source |
| immBytes | input | 3 | Encoded immediate size (1, 2, otherwise 4) |
| srcValue | input | 64 | Raw source value |
| stackPtr | input | 64 | Current stack pointer |
| outValid | output | 1 | Results valid |
| pushBytes | output | 4 | Push width in bytes |
| storeData | output | 64 | Formatted store data |
| newStackPtr | output | 64 | Decremented stack pointer |
| byteEnable | output | 8 | Byte write mask for the 64-bit lane |

## Verification
Some properties are checked by assertions on every cycle. The width decode is one-hot. The low 16 bits of the pointer drop by exactly pushBytes. The upper pointer bits are kept in the narrow modes. The mask is contiguous and matches pushBytes. No data bits are set above the width. outValid follows the input strobe. Other behaviour is shown only by the bench's reference model and its scenarios: the exact width chosen for each mode and prefix pair, the sign-extension values for each immediate size, wrap-around of the pointer at zero, and data being held through idle cycles.

// File: rtl/push_fmt_pkg.sv
package push_fmt_pkg;
  localparam int DATA_W = 64;
  localparam int LANE_BYTES = DATA_W / 8;

  typedef enum logic [1:0] {
    MODE16 = 2'b00,
    MODE32 = 2'b01,
    MODE64 = 2'b10,
    MODE64ALT = 2'b11
  } cpu_mode_e;

  typedef struct packed {
    logic load;
    logic w2;
    logic w4;
    logic w8;
    logic useImm;
    logic ext8;
    logic ext16;
    logic ext32;
    logic wrap16;
    logic wrap32;
  } ctrl_strobes_t;
endpackage

// File: rtl/push_ctrl.sv
module push_ctrl
  import push_fmt_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [1:0]    cpuMode,
  input  logic          sizeOverride,
  input  logic          srcIsImm,
  input  logic [2:0]    immBytes,
  output ctrl_strobes_t ctl
);
  cpu_mode_e modeE;
  assign modeE = cpu_mode_e'(cpuMode);

  always_comb begin
    ctl = '0;
    ctl.load = inValid;
    ctl.useImm = srcIsImm;
    unique case (modeE)
      MODE16: begin
        ctl.w2 = !sizeOverride;
        ctl.w4 = sizeOverride;
        ctl.wrap16 = 1'b1;
      end
      MODE32: begin
        ctl.w4 = !sizeOverride;
        ctl.w2 = sizeOverride;
        ctl.wrap32 = 1'b1;
      end
      default: begin
        ctl.w8 = !sizeOverride;
        ctl.w2 = sizeOverride;
      end
    endcase
    ctl.ext8 = (immBytes == 3'd1);
    ctl.ext16 = (immBytes == 3'd2);
    ctl.ext32 = !(ctl.ext8 || ctl.ext16);
  end

  // R1 R2 R3: one width strobe at a time
  p_width_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl.w2, ctl.w4, ctl.w8}) == 1);

  // R5: exactly one immediate size selected
  p_ext_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl.ext8, ctl.ext16, ctl.ext32}) == 1);
endmodule

// File: rtl/push_dpath.sv
module push_dpath
  import push_fmt_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_strobes_t ctl,
  input  logic [DW-1:0] srcValue,
  input  logic [DW-1:0] stackPtr,
  output logic          outValid,
  output logic [3:0]    pushBytes,
  output logic [DW-1:0] storeData,
  output logic [DW-1:0] newStackPtr,
  output logic [NB-1:0] byteEnable
);
  logic [DW-1:0] immExt, rawVal, keepMask, stepVal, diff, spNext, dataNext;
  logic [3:0]    widthNext;
  logic [NB-1:0] beNext;

  always_comb begin
    if (ctl.ext8)
      immExt = {{(DW-8){srcValue[7]}}, srcValue[7:0]};
    else if (ctl.ext16)
      immExt = {{(DW-16){srcValue[15]}}, srcValue[15:0]};
    else
      immExt = {{(DW-32){srcValue[31]}}, srcValue[31:0]};
    rawVal = ctl.useImm ? immExt : srcValue;
    if (ctl.w2)      keepMask = {{(DW-16){1'b0}}, 16'hFFFF};
    else if (ctl.w4) keepMask = {{(DW-32){1'b0}}, 32'hFFFF_FFFF};
    else             keepMask = '1;
    dataNext = rawVal & keepMask;
    widthNext = {ctl.w8, ctl.w4, ctl.w2, 1'b0};
    stepVal = DW'(widthNext);
    diff = stackPtr - stepVal;
    if (ctl.wrap16)      spNext = {stackPtr[DW-1:16], diff[15:0]};
    else if (ctl.wrap32) spNext = {stackPtr[DW-1:32], diff[31:0]};
    else                 spNext = diff;
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign beNext[i] = (i < int'(widthNext));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      pushBytes <= '0;
      storeData <= '0;
      newStackPtr <= '0;
      byteEnable <= '0;
    end else begin
      outValid <= ctl.load;
      if (ctl.load) begin
        pushBytes <= widthNext;
        storeData <= dataNext;
        newStackPtr <= spNext;
        byteEnable <= beNext;
      end
    end
  end

  // R4: low pointer bits drop by the width
  p_sp_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((($past(stackPtr) - newStackPtr) & 64'hFFFF) == 64'(pushBytes)));

  // R4: upper pointer bits kept in narrow modes
  p_upper16_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(ctl.wrap16)) |-> newStackPtr[DW-1:16] == $past(stackPtr[DW-1:16]));
  p_upper32_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(ctl.wrap32)) |-> newStackPtr[DW-1:32] == $past(stackPtr[DW-1:32]));

  // R7: mask contiguous from bit 0 and sized to the width
  p_be_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(byteEnable) == int'(pushBytes)) && byteEnable[0]
                 && (((byteEnable + 1) & byteEnable) == 0));

  // R6: nothing stored above the width
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (storeData >> (int'(pushBytes) * 8)) == '0);

  // R9: output valid tracks the strobe
  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> outValid);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> !outValid && $stable(storeData) && $stable(newStackPtr));
endmodule

// File: rtl/push_fmt.sv
module push_fmt
  import push_fmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [1:0]            cpuMode,
  input  logic                  sizeOverride,
  input  logic                  srcIsImm,
  input  logic [2:0]            immBytes,
  input  logic [DATA_W-1:0]     srcValue,
  input  logic [DATA_W-1:0]     stackPtr,
  output logic                  outValid,
  output logic [3:0]            pushBytes,
  output logic [DATA_W-1:0]     storeData,
  output logic [DATA_W-1:0]     newStackPtr,
  output logic [LANE_BYTES-1:0] byteEnable
);
  ctrl_strobes_t ctl;

  push_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .cpuMode(cpuMode),
    .sizeOverride(sizeOverride), .srcIsImm(srcIsImm), .immBytes(immBytes),
    .ctl(ctl)
  );

  push_dpath #(.DW(DATA_W), .NB(LANE_BYTES)) i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .srcValue(srcValue), .stackPtr(stackPtr),
    .outValid(outValid), .pushBytes(pushBytes), .storeData(storeData),
    .newStackPtr(newStackPtr), .byteEnable(byteEnable)
  );
endmodule

// File: tb/test_push_fmt.sv
module test_push_fmt;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] cpuMode = 2'b00;
  logic sizeOverride = 1'b0;
  logic srcIsImm = 1'b0;
  logic [2:0] immBytes = 3'd1;
  logic [63:0] srcValue = '0;
  logic [63:0] stackPtr = '0;
  logic outValid;
  logic [3:0] pushBytes;
  logic [63:0] storeData, newStackPtr;
  logic [7:0] byteEnable;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  logic expValid;
  logic [3:0] expBytes;
  logic [63:0] expData, expSp;
  logic [7:0] expBe;

  always #4 clk = ~clk;

  push_fmt i_push_fmt (
    .clk(clk), .rstN(rstN), .inValid(inValid), .cpuMode(cpuMode),
    .sizeOverride(sizeOverride), .srcIsImm(srcIsImm), .immBytes(immBytes),
    .srcValue(srcValue), .stackPtr(stackPtr), .outValid(outValid),
    .pushBytes(pushBytes), .storeData(storeData), .newStackPtr(newStackPtr),
    .byteEnable(byteEnable)
  );

  function automatic int refWidth(logic [1:0] m, logic ov);
    if (m == 2'b00) return ov ? 4 : 2;
    if (m == 2'b01) return ov ? 2 : 4;
    return ov ? 8 / 4 : 8;
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    check64({tag, " R9 outValid"}, 64'(outValid), 64'(expValid));
    check64({tag, " R1 R2 R3 R8 pushBytes"}, 64'(pushBytes), 64'(expBytes));
    check64({tag, " R5 R6 storeData"}, storeData, expData);
    check64({tag, " R4 newStackPtr"}, newStackPtr, expSp);
    check64({tag, " R7 byteEnable"}, 64'(byteEnable), 64'(expBe));
  endtask

  task automatic step(string tag, logic v, logic [1:0] m, logic ov, logic imm,
                      logic [2:0] nb, logic [63:0] src, logic [63:0] sp);
    int w;
    int n;
    logic [63:0] val;
    logic [63:0] d;
    inValid = v; cpuMode = m; sizeOverride = ov; srcIsImm = imm;
    immBytes = nb; srcValue = src; stackPtr = sp;
    expValid = v;
    if (v) begin
      w = refWidth(m, ov);
      val = src;
      if (imm) begin
        n = (nb == 3'd1) ? 1 : (nb == 3'd2) ? 2 : 4;
        for (int b = n * 8; b < 64; b++) val[b] = src[n * 8 - 1];
      end
      for (int b = w * 8; b < 64; b++) val[b] = 1'b0;
      expData = val;
      expBytes = 4'(w);
      expBe = 8'((1 << w) - 1);
      d = sp - 64'(w);
      if (m == 2'b00) expSp = {sp[63:16], d[15:0]};
      else if (m == 2'b01) expSp = {sp[63:32], d[31:0]};
      else expSp = d;
    end
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    expValid = 0; expBytes = 0; expData = 0; expSp = 0; expBe = 0;
    repeat (3) @(negedge clk);
    compareAll("R10 reset");
    rstN = 1'b1;
    // widths per mode and prefix, register source
    step("R1 m64", 1, 2'b10, 0, 0, 3'd1, 64'h1122334455667788, 64'h0000_7FFF_0000_1000);
    step("R1 m64 ovr", 1, 2'b10, 1, 0, 3'd1, 64'h1122334455667788, 64'h0000_7FFF_0000_1000);
    step("R1 m64alt", 1, 2'b11, 0, 0, 3'd4, 64'hDEADBEEFCAFEF00D, 64'h100);
    step("R2 m32", 1, 2'b01, 0, 0, 3'd1, 64'h1122334455667788, 64'hAAAA_BBBB_0000_2000);
    step("R2 m32 ovr", 1, 2'b01, 1, 0, 3'd1, 64'h1122334455667788, 64'hAAAA_BBBB_0000_2000);
    step("R3 m16", 1, 2'b00, 0, 0, 3'd1, 64'h1122334455667788, 64'hAAAA_BBBB_CCCC_0100);
    step("R3 m16 ovr", 1, 2'b00, 1, 0, 3'd1, 64'h1122334455667788, 64'hAAAA_BBBB_CCCC_0100);
    // immediates: sign-extension
    step("R5 imm1 neg w8", 1, 2'b10, 0, 1, 3'd1, 64'h0000_0000_0000_0080, 64'h1000);
    step("R5 imm4 neg w8", 1, 2'b10, 0, 1, 3'd4, 64'h1234_5678_8000_0000, 64'h1000);
    step("R5 imm1 neg w2", 1, 2'b00, 0, 1, 3'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h1000);
    step("R5 imm2 pos w4", 1, 2'b01, 0, 1, 3'd2, 64'hFFFF_FFFF_FFFF_7ABC, 64'h1000);
    step("R5 imm4 w2 trunc", 1, 2'b10, 1, 1, 3'd4, 64'h0000_0000_8765_4321, 64'h1000);
    step("R5 imm odd size", 1, 2'b10, 0, 1, 3'd7, 64'h0000_0000_9000_0001, 64'h1000);
    step("R8 imm1 pos w8", 1, 2'b10, 0, 1, 3'd1, 64'h0000_0000_0000_007F, 64'h1000);
    // pointer wrap-around
    step("R4 wrap16", 1, 2'b00, 0, 0, 3'd1, 64'h5, 64'h1234_5678_9ABC_0000);
    step("R4 wrap32", 1, 2'b01, 0, 0, 3'd1, 64'h5, 64'h1234_5678_0000_0002);
    step("R4 wrap64", 1, 2'b10, 0, 0, 3'd1, 64'h5, 64'h0);
    // idle cycles keep the data
    step("R9 idle", 0, 2'b01, 1, 1, 3'd2, 64'hFFFF, 64'h0);
    step("R9 idle2", 0, 2'b00, 0, 0, 3'd1, 64'h0, 64'hFFFF);
    for (int k = 0; k < 400; k++) begin
      step("R9 random", ($urandom % 4) != 0, 2'($urandom), 1'($urandom), 1'($urandom),
           3'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule